// File: doc/BRIEF.md
# Indexed Configuration Port Controller

This block exposes a two-byte configuration window on an I/O bus. A byte written to the lower address picks one of 256 configuration registers. An access to the upper address reads or writes the register that was picked. A host can therefore reach the whole register file through two I/O locations. The register that holds the current index is entry 0 of the file.

Some register writes also reconfigure the legacy peripherals next to the block. One register drives the enables for a parallel port, up to two serial ports and a floppy controller. Four other registers set the I/O base address of each of those devices. A base address is the stored byte shifted left by two bits.

Large parts of the index space are read-only. Writes to them are dropped without effect. Each writable register with a side effect applies its own bit mask before it stores the byte. The window answers only while an external enable input is high.

Top module: `cfgport_ctrl`

## Requirements
- R1: A write to address 0x3F0 stores the byte as the current index. A read of 0x3F0 returns the current index.
- R2: A read of 0x3F1 returns the register selected by the current index. When the index is 0x00 the read returns 0x00.
- R3: A write to 0x3F1 is dropped, and the stored byte stays the same, when the index lies in one of these sets: 0x00–0xDF, 0xE4, 0xE5, 0xE9–0xED, 0xF3, 0xF5, 0xF7, 0xF9–0xFB or 0xFD–0xFF.
- R4: Index 0xE2 stores data AND 0x1F. The stored byte drives the device enables:
  - the parallel port is enabled unless bits[1:0] equal 2'b11;
  - serial port i is enabled by bit i+2;
  - the floppy controller is enabled by bit 4.
- R5: Index 0xE3 stores data AND 0xFC. The 10-bit floppy base equals the stored byte shifted left by 2.
- R6: Index 0xE6 stores the data unmasked and sets the parallel base to the data shifted left by 2. Indices 0xE7 and 0xE8 store data AND 0xFE and set the serial 0 and serial 1 bases to the stored byte shifted left by 2.
- R7: A write to a writable index without a side effect (for example 0xE0, 0xEE, 0xF2, 0xFC) stores the whole byte and leaves every enable and base output unchanged.
- R8: After a synchronous reset:
  - the index is 0 and the register file is cleared, except 0xE0=0x3C, 0xE2=0x0F, 0xE3=0xFC, 0xE6=0xDE, 0xE7=0xFE and 0xE8=0xBE;
  - the parallel port and the floppy controller are disabled, and both serial ports are enabled;
  - the bases are floppy 0x3F0, parallel 0x378, serial 0 0x3F8 and serial 1 0x2F8.
- R9: The block responds only at 0x3F0 and 0x3F1, and only while `port_en` is high. Any other access is ignored, and `io_rdata` is 0x00 when the block does not respond.
- R10: The enable and base outputs keep their old values while a data write is presented. They change on the clock edge that accepts the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| port_en | input | 1 | Opens the configuration window |
| io_addr | input | 16 | I/O address of the access |
| io_wr | input | 1 | Write strobe, one cycle per byte |
| io_rd | input | 1 | Read strobe |
| io_wdata | input | 8 | Write byte |
| io_rdata | output | 8 | Read byte, combinational, zero when the block does not respond |
| par_en | output | 1 | Parallel port enable |
| ser_en | output | 2 | Serial port enables, bit i for port i |
| fdc_en | output | 1 | Floppy controller enable |
| par_base | output | 10 | Parallel port I/O base |
| ser_base | output | 20 | Serial port bases, port i in bits [10*i+9:10*i] |
| fdc_base | output | 10 | Floppy controller I/O base |

## Verification
The assertions assume three things about the inputs:
- the host presents at most one strobe in a cycle;
- a strobe carries a single byte;
- reset is held for at least one clock edge.

Without these, the rules for index capture and output stability would not hold. The bench drives exactly one read or one write per task call, always at the falling edge. It pulses the write strobe for a single cycle and holds reset for several cycles, so every stimulus meets these assumptions.

// File: rtl/cfgport_pkg.sv
package cfgport_pkg;

    localparam int IDX_W      = 8;
    localparam int DATA_W     = 8;
    localparam int BASE_W     = DATA_W + 2;
    localparam int MAX_SERIAL = 2;

    localparam logic [IDX_W-1:0] IX_ID   = 8'hE0;
    localparam logic [IDX_W-1:0] IX_FUNC = 8'hE2;
    localparam logic [IDX_W-1:0] IX_FDC  = 8'hE3;
    localparam logic [IDX_W-1:0] IX_PAR  = 8'hE6;
    localparam logic [IDX_W-1:0] IX_SER0 = 8'hE7;

    typedef struct packed {
        logic              keep;
        logic [DATA_W-1:0] value;
    } wr_res_t;

    typedef struct packed {
        logic                  par;
        logic [MAX_SERIAL-1:0] ser;
        logic                  fdc;
    } fsel_t;

    typedef struct packed {
        logic idx_we;
        logic dat_we;
        logic idx_re;
        logic dat_re;
    } port_req_t;

    function automatic logic idx_readonly(input logic [IDX_W-1:0] ix);
        return (ix <= 8'hDF) || (ix == 8'hE4) || (ix == 8'hE5) ||
               (ix >= 8'hE9 && ix <= 8'hED) || (ix == 8'hF3) ||
               (ix == 8'hF5) || (ix == 8'hF7) ||
               (ix >= 8'hF9 && ix <= 8'hFB) || (ix >= 8'hFD);
    endfunction

    function automatic logic [DATA_W-1:0] idx_mask(input logic [IDX_W-1:0] ix);
        case (ix)
            IX_FUNC:        return 8'h1F;
            IX_FDC:         return 8'hFC;
            8'hE7, 8'hE8:   return 8'hFE;
            default:        return 8'hFF;
        endcase
    endfunction

    function automatic logic idx_side_effect(input logic [IDX_W-1:0] ix);
        return (ix == IX_FUNC) || (ix == IX_FDC) || (ix == IX_PAR) ||
               (ix == 8'hE7) || (ix == 8'hE8);
    endfunction

    function automatic wr_res_t filter_write(input logic [IDX_W-1:0] ix,
                                             input logic [DATA_W-1:0] d);
        wr_res_t r;
        r.keep  = !idx_readonly(ix);
        r.value = d & idx_mask(ix);
        return r;
    endfunction

    function automatic logic [DATA_W-1:0] boot_value(input logic [IDX_W-1:0] ix);
        case (ix)
            IX_ID:   return 8'h3C;
            IX_FUNC: return 8'h0F;
            IX_FDC:  return 8'hFC;
            IX_PAR:  return 8'hDE;
            8'hE7:   return 8'hFE;
            8'hE8:   return 8'hBE;
            default: return 8'h00;
        endcase
    endfunction

    function automatic logic [DATA_W-1:0] boot_entry(input logic [IDX_W-1:0] ix);
        wr_res_t r;
        r = filter_write(ix, boot_value(ix));
        return r.keep ? r.value : '0;
    endfunction

    function automatic fsel_t func_decode(input logic [DATA_W-1:0] v);
        fsel_t f;
        f.par = (v[1:0] != 2'b11);
        for (int i = 0; i < MAX_SERIAL; i++) f.ser[i] = v[i+2];
        f.fdc = v[4];
        return f;
    endfunction

    function automatic logic [BASE_W-1:0] to_base(input logic [DATA_W-1:0] v);
        return {v, 2'b00};
    endfunction

endpackage

// File: rtl/cfgport_decode.sv
module cfgport_decode
    import cfgport_pkg::*;
#(
    parameter int                ADDR_W    = 16,
    parameter logic [ADDR_W-1:0] PORT_BASE = 16'h03F0
) (
    input  logic              port_en,
    input  logic [ADDR_W-1:0] io_addr,
    input  logic              io_wr,
    input  logic              io_rd,
    output port_req_t         req
);
    localparam logic [ADDR_W-1:0] DATA_ADDR = PORT_BASE + ADDR_W'(1);

    logic hit_idx, hit_dat;

    assign hit_idx = port_en && (io_addr == PORT_BASE);
    assign hit_dat = port_en && (io_addr == DATA_ADDR);

    always_comb begin
        req.idx_we = hit_idx && io_wr;
        req.dat_we = hit_dat && io_wr;
        req.idx_re = hit_idx && io_rd;
        req.dat_re = hit_dat && io_rd;
    end
endmodule

// File: rtl/cfgport_regfile.sv
module cfgport_regfile
    import cfgport_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              idx_we,
    input  logic              dat_we,
    input  logic [DATA_W-1:0] wdata,
    output logic [IDX_W-1:0]  idx_q,
    output logic [DATA_W-1:0] sel_q
);
    localparam int DEPTH = 1 << IDX_W;

    logic [DATA_W-1:0] mem [DEPTH];
    wr_res_t           fw;

    assign fw = filter_write(idx_q, wdata);

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < DEPTH; i++) mem[i] <= boot_entry(IDX_W'(i));
        end else begin
            if (idx_we) mem[0] <= wdata;
            if (dat_we && fw.keep) mem[idx_q] <= fw.value;
        end
    end

    assign idx_q = mem[0];
    assign sel_q = mem[idx_q];

    a_r1_index_capture: assert property (@(posedge clk) disable iff (rst)
        idx_we |=> idx_q == $past(wdata));

    a_r3_readonly_hold: assert property (@(posedge clk) disable iff (rst)
        (dat_we && !idx_we && idx_readonly(idx_q)) |=> $stable(sel_q));
endmodule

// File: rtl/cfgport_devmap.sv
module cfgport_devmap
    import cfgport_pkg::*;
#(
    parameter int NUM_SERIAL = 2
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic                         we,
    input  logic [IDX_W-1:0]             ix,
    input  logic [DATA_W-1:0]            wdata,
    output logic                         par_en,
    output logic [NUM_SERIAL-1:0]        ser_en,
    output logic                         fdc_en,
    output logic [BASE_W-1:0]            par_base,
    output logic [NUM_SERIAL*BASE_W-1:0] ser_base,
    output logic [BASE_W-1:0]            fdc_base
);
    localparam fsel_t BOOT_SEL = func_decode(boot_entry(IX_FUNC));

    wr_res_t fw;
    fsel_t   new_sel;
    logic    upd;

    assign fw      = filter_write(ix, wdata);
    assign upd     = we && fw.keep;
    assign new_sel = func_decode(fw.value);

    always_ff @(posedge clk) begin
        if (rst) begin
            par_en   <= BOOT_SEL.par;
            fdc_en   <= BOOT_SEL.fdc;
            par_base <= to_base(boot_entry(IX_PAR));
            fdc_base <= to_base(boot_entry(IX_FDC));
        end else if (upd) begin
            if (ix == IX_FUNC) begin
                par_en <= new_sel.par;
                fdc_en <= new_sel.fdc;
            end
            if (ix == IX_PAR) par_base <= to_base(fw.value);
            if (ix == IX_FDC) fdc_base <= to_base(fw.value);
        end
    end

    for (genvar i = 0; i < NUM_SERIAL; i++) begin : g_ser
        localparam logic [IDX_W-1:0] SIX = IX_SER0 + IDX_W'(i);
        logic              en_q;
        logic [BASE_W-1:0] base_q;

        always_ff @(posedge clk) begin
            if (rst) begin
                en_q   <= BOOT_SEL.ser[i];
                base_q <= to_base(boot_entry(SIX));
            end else if (upd) begin
                if (ix == IX_FUNC) en_q <= new_sel.ser[i];
                if (ix == SIX) base_q <= to_base(fw.value);
            end
        end

        assign ser_en[i]                   = en_q;
        assign ser_base[i*BASE_W +: BASE_W] = base_q;
    end

    a_r4_floppy_enable_bit: assert property (@(posedge clk) disable iff (rst)
        (we && ix == IX_FUNC) |=> fdc_en == $past(wdata[4]));

    a_r4_parallel_code: assert property (@(posedge clk) disable iff (rst)
        (we && ix == IX_FUNC) |=> par_en == ($past(wdata[1:0]) != 2'b11));

    a_r7_outputs_hold: assert property (@(posedge clk) disable iff (rst)
        !(we && idx_side_effect(ix)) |=>
            $stable({par_en, ser_en, fdc_en, par_base, ser_base, fdc_base}));

    a_r5_floppy_align: assert property (@(posedge clk) disable iff (rst)
        fdc_base[3:0] == 4'h0);
endmodule

// File: rtl/cfgport_ctrl.sv
module cfgport_ctrl
    import cfgport_pkg::*;
#(
    parameter int                ADDR_W     = 16,
    parameter logic [ADDR_W-1:0] PORT_BASE  = 16'h03F0,
    parameter int                NUM_SERIAL = 2
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic                         port_en,
    input  logic [ADDR_W-1:0]            io_addr,
    input  logic                         io_wr,
    input  logic                         io_rd,
    input  logic [DATA_W-1:0]            io_wdata,
    output logic [DATA_W-1:0]            io_rdata,
    output logic                         par_en,
    output logic [NUM_SERIAL-1:0]        ser_en,
    output logic                         fdc_en,
    output logic [BASE_W-1:0]            par_base,
    output logic [NUM_SERIAL*BASE_W-1:0] ser_base,
    output logic [BASE_W-1:0]            fdc_base
);
    port_req_t         req;
    logic [IDX_W-1:0]  idx_q;
    logic [DATA_W-1:0] sel_q;

    cfgport_decode #(.ADDR_W(ADDR_W), .PORT_BASE(PORT_BASE)) u_dec (
        .port_en (port_en),
        .io_addr (io_addr),
        .io_wr   (io_wr),
        .io_rd   (io_rd),
        .req     (req)
    );

    cfgport_regfile u_rf (
        .clk    (clk),
        .rst    (rst),
        .idx_we (req.idx_we),
        .dat_we (req.dat_we),
        .wdata  (io_wdata),
        .idx_q  (idx_q),
        .sel_q  (sel_q)
    );

    cfgport_devmap #(.NUM_SERIAL(NUM_SERIAL)) u_map (
        .clk      (clk),
        .rst      (rst),
        .we       (req.dat_we),
        .ix       (idx_q),
        .wdata    (io_wdata),
        .par_en   (par_en),
        .ser_en   (ser_en),
        .fdc_en   (fdc_en),
        .par_base (par_base),
        .ser_base (ser_base),
        .fdc_base (fdc_base)
    );

    always_comb begin
        io_rdata = '0;
        if (req.idx_re)
            io_rdata = idx_q;
        else if (req.dat_re && idx_q != '0)
            io_rdata = sel_q;
    end

    a_r9_closed_silent: assert property (@(posedge clk) disable iff (rst)
        !port_en |-> io_rdata == '0);

    a_r2_index_zero_read: assert property (@(posedge clk) disable iff (rst)
        (port_en && io_rd && io_addr == PORT_BASE + ADDR_W'(1) && idx_q == '0)
            |-> io_rdata == '0);
endmodule

// File: tb/sim_cfgport_ctrl.sv
module sim_cfgport_ctrl;
    localparam logic [15:0] BASE = 16'h03F0;
    localparam int          NV   = 16;

    // each entry: index, written byte, expected read-back
    localparam logic [23:0] TBL [NV] = '{
        {8'hE0, 8'h55, 8'h55}, {8'hE1, 8'hA5, 8'hA5}, {8'hE4, 8'h77, 8'h00},
        {8'hE2, 8'hFF, 8'h1F}, {8'hE3, 8'hFF, 8'hFC}, {8'hE6, 8'hFF, 8'hFF},
        {8'hE7, 8'hFF, 8'hFE}, {8'hE8, 8'h03, 8'h02}, {8'hF7, 8'h12, 8'h00},
        {8'hF2, 8'hFF, 8'hFF}, {8'h10, 8'hAA, 8'h00}, {8'hFC, 8'h33, 8'h33},
        {8'hDF, 8'h11, 8'h00}, {8'hED, 8'h09, 8'h00}, {8'hEE, 8'hC3, 8'hC3},
        {8'hFF, 8'h44, 8'h00}
    };

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        port_en = 1'b1;
    logic [15:0] io_addr = '0;
    logic        io_wr = 1'b0;
    logic        io_rd = 1'b0;
    logic [7:0]  io_wdata = '0;
    logic [7:0]  io_rdata;
    logic        par_en, fdc_en;
    logic [1:0]  ser_en;
    logic [9:0]  par_base, fdc_base;
    logic [19:0] ser_base;

    int n_run = 0;
    int n_fail = 0;
    logic [7:0] got;

    always #5 clk = ~clk;

    cfgport_ctrl u0 (
        .clk(clk), .rst(rst), .port_en(port_en), .io_addr(io_addr),
        .io_wr(io_wr), .io_rd(io_rd), .io_wdata(io_wdata), .io_rdata(io_rdata),
        .par_en(par_en), .ser_en(ser_en), .fdc_en(fdc_en),
        .par_base(par_base), .ser_base(ser_base), .fdc_base(fdc_base)
    );

    task automatic chk(input string what, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", what, act, exp);
        end
    endtask

    task automatic io_write(input logic [15:0] a, input logic [7:0] d);
        @(negedge clk);
        io_addr = a; io_wdata = d; io_wr = 1'b1;
        @(negedge clk);
        io_wr = 1'b0;
    endtask

    task automatic io_read(input logic [15:0] a, output logic [7:0] d);
        @(negedge clk);
        io_addr = a; io_rd = 1'b1;
        #1 d = io_rdata;
        io_rd = 1'b0;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic finish_run();
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_run++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        do_reset();

        // R8 reset state
        chk("R8 par_en", par_en, 0);
        chk("R8 ser_en", ser_en, 2'b11);
        chk("R8 fdc_en", fdc_en, 0);
        chk("R8 fdc_base", fdc_base, 10'h3F0);
        chk("R8 par_base", par_base, 10'h378);
        chk("R8 ser0_base", ser_base[9:0], 10'h3F8);
        chk("R8 ser1_base", ser_base[19:10], 10'h2F8);
        io_read(BASE, got);       chk("R8 index zero", got, 8'h00);
        io_write(BASE, 8'hE0);
        io_read(BASE + 1, got);   chk("R8 id byte", got, 8'h3C);
        io_write(BASE, 8'hE8);
        io_read(BASE + 1, got);   chk("R8 serial1 byte", got, 8'hBE);
        io_write(BASE, 8'h50);
        io_read(BASE + 1, got);   chk("R8 cleared entry", got, 8'h00);

        // table walk: R1 index, R2 read, R3 drops, R4-R7 masks
        for (int i = 0; i < NV; i++) begin
            io_write(BASE, TBL[i][23:16]);
            io_read(BASE, got);
            chk($sformatf("R1 index %0h", TBL[i][23:16]), got, TBL[i][23:16]);
            io_write(BASE + 1, TBL[i][15:8]);
            io_read(BASE + 1, got);
            chk($sformatf("R2/R3 readback idx %0h", TBL[i][23:16]), got, TBL[i][7:0]);
        end
        chk("R4 par_en after 1F", par_en, 0);
        chk("R4 ser_en after 1F", ser_en, 2'b11);
        chk("R4 fdc_en after 1F", fdc_en, 1);
        chk("R5 fdc_base", fdc_base, 10'h3F0);
        chk("R6 par_base", par_base, 10'h3FC);
        chk("R6 ser0_base", ser_base[9:0], 10'h3F8);
        chk("R6 ser1_base", ser_base[19:10], 10'h008);

        // R2 index zero reads zero on the data byte
        io_write(BASE, 8'h00);
        io_read(BASE + 1, got);   chk("R2 index0 data", got, 8'h00);

        // R4 enable decode patterns
        io_write(BASE, 8'hE2);
        io_write(BASE + 1, 8'h14);
        chk("R4 par on code0", par_en, 1);
        chk("R4 ser_en 14", ser_en, 2'b01);
        chk("R4 fdc on", fdc_en, 1);
        io_write(BASE + 1, 8'h0A);
        chk("R4 par on code2", par_en, 1);
        chk("R4 ser_en 0A", ser_en, 2'b10);
        chk("R4 fdc off", fdc_en, 0);
        io_write(BASE + 1, 8'h03);
        chk("R4 par off code3", par_en, 0);

        // R10 timing of the base update
        io_write(BASE, 8'hE3);
        @(negedge clk);
        io_addr = BASE + 1; io_wdata = 8'h40; io_wr = 1'b1;
        #1 chk("R10 before edge", fdc_base, 10'h3F0);
        @(negedge clk);
        io_wr = 1'b0;
        chk("R10 after edge", fdc_base, 10'h100);

        // R3 read-only write keeps outputs and stored byte
        io_write(BASE, 8'hE5);
        io_write(BASE + 1, 8'hFF);
        io_read(BASE + 1, got);   chk("R3 E5 dropped", got, 8'h00);

        // R7 plain writable index
        io_write(BASE, 8'hF0);
        io_write(BASE + 1, 8'h5A);
        io_read(BASE + 1, got);   chk("R7 F0 stored", got, 8'h5A);
        chk("R7 fdc_base kept", fdc_base, 10'h100);
        chk("R7 par_en kept", par_en, 0);

        // R9 enable gating and address decode
        io_write(BASE, 8'hE3);
        port_en = 1'b0;
        io_read(BASE, got);       chk("R9 closed read", got, 8'h00);
        io_write(BASE, 8'hE6);
        io_write(BASE + 1, 8'h00);
        chk("R9 closed write no base", fdc_base, 10'h100);
        port_en = 1'b1;
        io_read(BASE, got);       chk("R9 index kept", got, 8'hE3);
        io_write(BASE + 2, 8'hE7);
        io_read(BASE, got);       chk("R9 other address", got, 8'hE3);
        io_read(BASE + 2, got);   chk("R9 other address read", got, 8'h00);

        // second reset restores defaults
        do_reset();
        chk("R8 fdc_base again", fdc_base, 10'h3F0);
        chk("R8 ser_en again", ser_en, 2'b11);
        io_read(BASE, got);       chk("R8 index again", got, 8'h00);

        finish_run();
    end
endmodule